// File: doc/BRIEF.md
# Receive FIFO Interrupt and Character Timeout

This block produces the two receive-side interrupt flags of a FIFO-based serial receiver. The first flag, data ready, is raised while the receive FIFO holds at least the programmed trigger level of characters. The FIFO may hold more characters than the trigger level. The second flag, timeout, is raised when characters remain in a non-empty FIFO for too long. It fires when a number of bit times passes with no new stop bit arriving and no host read of the receive holding register.

The timeout length depends on the programmed character width P, and equals 4·P + 12 bit times. A counter advances on a bit-time tick from the baud logic. The counter restarts at the centre of every received stop bit and at every host read. It is held at zero while the FIFO is empty, and it stops (saturates) at the limit. The limit is captured from the width setting at each restart, so a width change made mid-count applies from the next restart. Both flags are gated by a single receive-interrupt enable and share one priority level, so an interrupt controller may treat them as one source.

Top module: `rx_irq_timeout`

## Requirements
- R1: While rst_n is low at a clock edge, both data_ready_irq and timeout_irq are 0 after that edge.
- R2: When rx_irq_en is 1, fifo_count is nonzero and fifo_count >= trig_level at a clock edge, data_ready_irq is 1 after that edge, including when the count exceeds the trigger level.
- R3: When fifo_count < trig_level or fifo_count is 0 at a clock edge, data_ready_irq is 0 after that edge.
- R4: The timeout limit is T = 4·P + 12 bit ticks, where word_len_sel 2'b00, 2'b01, 2'b10 and 2'b11 select P = 5, 6, 7 and 8 (T = 32, 36, 40, 44). timeout_irq becomes 1 one edge after the edge that samples the T-th bit_tick following a restart, and it stays 0 before that.
- R5: A stop_mid pulse restarts the count from zero. timeout_irq is 0 after the edge that samples the pulse.
- R6: An rhr_read pulse restarts the count from zero. timeout_irq is 0 after the edge that samples the pulse.
- R7: While fifo_count is 0, the count is held at zero and timeout_irq is 0 one edge later, however many bit ticks arrive.
- R8: The count saturates at T. Once timeout_irq is 1, it stays 1 under further bit ticks until a restart, an empty FIFO or a disable.
- R9: When rx_irq_en is 0 at an edge, both flags are 0 after that edge. The count keeps running, so re-enabling shows the current state.
- R10: The limit T is latched from word_len_sel only at a restart or while the FIFO is empty. A change of word_len_sel in between does not alter the running limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per received bit time |
| word_len_sel | input | 2 | Character width select: 0..3 map to 5..8 bits |
| stop_mid | input | 1 | One-cycle strobe at the centre of a received stop bit |
| rhr_read | input | 1 | One-cycle strobe on a host read of the receive holding register |
| fifo_count | input | $clog2(FIFO_DEPTH+1) | Characters currently in the receive FIFO |
| trig_level | input | $clog2(FIFO_DEPTH+1) | Programmed receive trigger level |
| rx_irq_en | input | 1 | Receive interrupt enable (data ready and timeout) |
| data_ready_irq | output | 1 | FIFO level has reached the trigger level |
| timeout_irq | output | 1 | Character timeout expired on a non-empty FIFO |

## Verification
Both flags come from one register stage. Each therefore follows its qualifying inputs by exactly one clock edge. The timeout rises one edge after the edge that samples the T-th bit tick. The bench changes inputs on the falling edge, and it compares both outputs on the next falling edge with a cycle model that is stepped on each rising edge. Directed phases send bit ticks one at a time, so the check that comes just before the T-th tick and the check that comes just after it land on known edges. These phases cover the 32- and 40-tick limits, a width change in the middle of a count, a restart by read and by stop bit, an empty FIFO and the disabled state.

// File: rtl/rxto_pkg.sv
// Shared constants and the timeout-length function for the receive
// interrupt block. Assumes the width select covers 5 to 8 data bits.
package rxto_pkg;
    // Wide enough for the longest limit, 4*8+12 = 44.
    localparam int TMR_W = 6;
    localparam int MIN_BITS = 5;

    // Timeout length in bit ticks for a character-width select value.
    function automatic logic [TMR_W-1:0] timeout_len(input logic [1:0] sel);
        return TMR_W'(4 * (int'(sel) + MIN_BITS) + 12);
    endfunction
endpackage

// File: rtl/rxto_level_cmp.sv
// Trigger-level compare. Reports that the FIFO count has reached the
// trigger level. An empty FIFO never qualifies, even with a level of zero.
// Purely combinational. The caller registers the result.
module rxto_level_cmp #(
    parameter int CNT_W = 5
) (
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [CNT_W-1:0] trig_level,
    output logic             level_hit
);
    // Compare the current count against the programmed level.
    always_comb begin
        level_hit = (fifo_count != '0) && (fifo_count >= trig_level);
    end
endmodule

// File: rtl/rxto_timer.sv
// Character timeout counter. It counts bit ticks up to a limit, which it
// latches at each restart or while held. Assumes bit_tick, restart and
// hold are single-clock-domain strobes or levels.
module rxto_timer
    import rxto_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             restart,
    input  logic             hold,
    input  logic [1:0]       word_len_sel,
    output logic [TMR_W-1:0] tmr_q,
    output logic [TMR_W-1:0] lim_q,
    output logic             expired
);
    logic [TMR_W-1:0] lim_next;

    // Limit that a restart would capture now.
    always_comb begin
        lim_next = timeout_len(word_len_sel);
    end

    // Count ticks, saturate at the limit, and reload on restart or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
            lim_q <= lim_next;
        end else if (restart || hold) begin
            tmr_q <= '0;
            lim_q <= lim_next;
        end else if (bit_tick && (tmr_q != lim_q)) begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    // Limit reached.
    always_comb begin
        expired = (tmr_q == lim_q);
    end
endmodule

// File: rtl/rxto_flag_reg.sv
// Output flag register. It gates both receive interrupt flags with the
// enable. It drops the timeout flag in the same edge that restarts or
// empties the counter, so the flag never outlives its cause.
module rxto_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_en,
    input  logic level_hit,
    input  logic expired,
    input  logic fifo_empty,
    input  logic restart,
    output logic data_ready_q,
    output logic timeout_q
);
    // Register both flags from their qualifying conditions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_ready_q <= 1'b0;
            timeout_q    <= 1'b0;
        end else begin
            data_ready_q <= irq_en && level_hit;
            timeout_q    <= irq_en && expired && !fifo_empty && !restart;
        end
    end
endmodule

// File: rtl/rx_irq_timeout.sv
// Receive interrupt source. It combines the trigger-level compare, the
// character timeout counter and the output flag register. Assumes all
// inputs are synchronous to clk and that strobes last one cycle.
module rx_irq_timeout
    import rxto_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic [1:0]       word_len_sel,
    input  logic             stop_mid,
    input  logic             rhr_read,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [CNT_W-1:0] trig_level,
    input  logic             rx_irq_en,
    output logic             data_ready_irq,
    output logic             timeout_irq
);
    logic             fifo_empty;
    logic             restart;
    logic             level_hit;
    logic             expired;
    logic [TMR_W-1:0] tmr_q;
    logic [TMR_W-1:0] lim_q;

    // Shared restart and empty conditions.
    always_comb begin
        fifo_empty = (fifo_count == '0);
        restart    = stop_mid || rhr_read;
    end

    rxto_level_cmp #(.CNT_W(CNT_W)) u_level (
        .fifo_count (fifo_count),
        .trig_level (trig_level),
        .level_hit  (level_hit)
    );

    rxto_timer u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_tick     (bit_tick),
        .restart      (restart),
        .hold         (fifo_empty),
        .word_len_sel (word_len_sel),
        .tmr_q        (tmr_q),
        .lim_q        (lim_q),
        .expired      (expired)
    );

    rxto_flag_reg u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_en       (rx_irq_en),
        .level_hit    (level_hit),
        .expired      (expired),
        .fifo_empty   (fifo_empty),
        .restart      (restart),
        .data_ready_q (data_ready_irq),
        .timeout_q    (timeout_irq)
    );
endmodule

// File: rtl/rxto_checker.sv
// Property checker for rx_irq_timeout, attached by bind. It observes the
// ports and the counter state only.
module rxto_checker
    import rxto_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop_mid,
    input logic             rhr_read,
    input logic [CNT_W-1:0] fifo_count,
    input logic [CNT_W-1:0] trig_level,
    input logic             rx_irq_en,
    input logic             data_ready_irq,
    input logic             timeout_irq,
    input logic [TMR_W-1:0] tmr_q,
    input logic [TMR_W-1:0] lim_q
);
    assert_level_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq_en && fifo_count != '0 && fifo_count >= trig_level) |=> data_ready_irq);

    assert_level_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count < trig_level || fifo_count == '0) |=> !data_ready_irq);

    assert_stop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mid |=> !timeout_irq);

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rhr_read |=> !timeout_irq);

    assert_empty_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count == '0) |=> (!timeout_irq && tmr_q == '0));

    assert_no_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q <= lim_q);

    assert_timeout_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_irq && rx_irq_en && fifo_count != '0 && !stop_mid && !rhr_read)
        |=> timeout_irq);

    assert_disable_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_irq_en |=> (!data_ready_irq && !timeout_irq));

    assert_limit_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_count != '0 && !stop_mid && !rhr_read) |=> $stable(lim_q));
endmodule

bind rx_irq_timeout rxto_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .stop_mid       (stop_mid),
    .rhr_read       (rhr_read),
    .fifo_count     (fifo_count),
    .trig_level     (trig_level),
    .rx_irq_en      (rx_irq_en),
    .data_ready_irq (data_ready_irq),
    .timeout_irq    (timeout_irq),
    .tmr_q          (tmr_q),
    .lim_q          (lim_q)
);

// File: tb/tb_rx_irq_timeout.sv
`timescale 1ns/1ps
module tb_rx_irq_timeout;
    localparam int DEPTH = 16;
    localparam int CW = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_tick = 1'b0;
    logic [1:0]    word_len_sel = 2'd0;
    logic          stop_mid = 1'b0;
    logic          rhr_read = 1'b0;
    logic [CW-1:0] fifo_count = '0;
    logic [CW-1:0] trig_level = '0;
    logic          rx_irq_en = 1'b0;
    logic          data_ready_irq;
    logic          timeout_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rx_irq_timeout #(.FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .word_len_sel(word_len_sel),
        .stop_mid(stop_mid), .rhr_read(rhr_read), .fifo_count(fifo_count),
        .trig_level(trig_level), .rx_irq_en(rx_irq_en),
        .data_ready_irq(data_ready_irq), .timeout_irq(timeout_irq)
    );

    // Limit from the requirement: 4*P + 12, with P = 5 + select.
    function automatic int limit_of(input logic [1:0] sel);
        return 4 * (int'(sel) + 5) + 12;
    endfunction

    // Cycle model of the required behaviour, stepped at each rising edge.
    int m_cnt = 0;
    int m_lim = 32;
    bit m_dr = 1'b0;
    bit m_to = 1'b0;
    always @(posedge clk) begin
        bit emp;
        bit rs;
        bit n_dr;
        bit n_to;
        if (!rst_n) begin
            m_cnt = 0; m_lim = limit_of(word_len_sel); m_dr = 1'b0; m_to = 1'b0;
        end else begin
            emp  = (fifo_count == '0);
            rs   = stop_mid || rhr_read;
            n_dr = rx_irq_en && !emp && (fifo_count >= trig_level);
            n_to = rx_irq_en && (m_cnt == m_lim) && !emp && !rs;
            if (emp || rs) begin
                m_cnt = 0; m_lim = limit_of(word_len_sel);
            end else if (bit_tick && m_cnt != m_lim) begin
                m_cnt = m_cnt + 1;
            end
            m_dr = n_dr; m_to = n_to;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Every cycle, compare both flags against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(m_dr ? "R2 data ready model" : "R3 data ready model", data_ready_irq, m_dr);
            check("R4 timeout model", timeout_irq, m_to);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1; @(negedge clk);
            bit_tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic pulse_stop();
        stop_mid = 1'b1; @(negedge clk); stop_mid = 1'b0;
    endtask

    task automatic pulse_read();
        rhr_read = 1'b1; @(negedge clk); rhr_read = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        idle(3);
        check("R1 reset data ready", data_ready_irq, 1'b0);
        check("R1 reset timeout", timeout_irq, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // Trigger level: below, at, above, then below again.
        rx_irq_en = 1'b1; trig_level = CW'(4);
        fifo_count = CW'(3); idle(1);
        check("R3 below level", data_ready_irq, 1'b0);
        fifo_count = CW'(4); idle(1);
        check("R2 at level", data_ready_irq, 1'b1);
        fifo_count = CW'(9); idle(1);
        check("R2 above level", data_ready_irq, 1'b1);
        fifo_count = CW'(2); idle(1);
        check("R3 falls below", data_ready_irq, 1'b0);

        // 7-bit characters: 40 ticks.
        word_len_sel = 2'b10; fifo_count = CW'(3); trig_level = CW'(8);
        pulse_stop();
        ticks(39);
        check("R4 before 40th tick", timeout_irq, 1'b0);
        ticks(1);
        check("R4 after 40th tick", timeout_irq, 1'b1);
        ticks(10);
        check("R8 saturated hold", timeout_irq, 1'b1);
        pulse_read();
        check("R6 read clears", timeout_irq, 1'b0);
        ticks(40);
        check("R6 rearmed after read", timeout_irq, 1'b1);
        pulse_stop();
        check("R5 stop bit clears", timeout_irq, 1'b0);

        // Width change without a restart keeps the latched 40.
        word_len_sel = 2'b11;
        ticks(40);
        check("R10 old limit kept", timeout_irq, 1'b1);
        pulse_stop();
        ticks(43);
        check("R10 new limit 44 not yet", timeout_irq, 1'b0);
        ticks(1);
        check("R10 new limit 44 reached", timeout_irq, 1'b1);

        // Enable low masks both flags; re-enable restores them.
        trig_level = CW'(2);
        rx_irq_en = 1'b0; idle(1);
        check("R9 disabled timeout", timeout_irq, 1'b0);
        check("R9 disabled data ready", data_ready_irq, 1'b0);
        rx_irq_en = 1'b1; idle(1);
        check("R9 re-enabled timeout", timeout_irq, 1'b1);
        check("R9 re-enabled data ready", data_ready_irq, 1'b1);

        // Empty FIFO clears and suppresses.
        fifo_count = '0; idle(1);
        check("R7 empty clears", timeout_irq, 1'b0);
        ticks(60);
        check("R7 empty suppresses", timeout_irq, 1'b0);
        check("R3 empty no data ready", data_ready_irq, 1'b0);

        // 5-bit characters: 32 ticks, starting from the empty hold.
        word_len_sel = 2'b00; idle(1);
        fifo_count = CW'(1);
        ticks(31);
        check("R4 before 32nd tick", timeout_irq, 1'b0);
        ticks(1);
        check("R4 after 32nd tick", timeout_irq, 1'b1);

        // Constrained random: rare strobes, frequent ticks.
        for (int i = 0; i < 6000; i++) begin
            bit_tick   = ($urandom % 3) != 0;
            stop_mid   = ($urandom % 97) == 0;
            rhr_read   = ($urandom % 89) == 0;
            if (($urandom % 53) == 0) fifo_count = CW'($urandom % (DEPTH + 1));
            if (($urandom % 211) == 0) trig_level = CW'($urandom % (DEPTH + 1));
            if (($urandom % 151) == 0) word_len_sel = 2'($urandom % 4);
            if (($urandom % 301) == 0) rx_irq_en = ~rx_irq_en;
            @(negedge clk);
        end
        bit_tick = 1'b0; stop_mid = 1'b0; rhr_read = 1'b0;
        idle(2);

        // Reset in mid-run clears both flags.
        rst_n = 1'b0; idle(1);
        check("R1 reset mid-run timeout", timeout_irq, 1'b0);
        check("R1 reset mid-run data ready", data_ready_irq, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule